// File: doc/BRIEF.md
# Linear CCD Line Timing Controller

This block drives a linear CCD sensor that has its own clock driver on chip. It produces two drive signals. The first is a pixel shift clock. The second is a readout-gate pulse, which moves the charge collected in the photo sites into the shift register and so starts a new line. The two signals never overlap. The shift clock rests low for a programmable guard time before the gate pulse rises and again after the gate pulse falls.

Each line lasts 2087 shift-clock periods. The first 33 periods are leading dummies, and 18 of those carry optically shielded dark-reference pixels. Then come 2048 image pixels, then 6 trailing dummies. For every period the controller reports a class code, and during image periods it also reports the image-pixel index. A downstream converter gets a one-clock sample strobe at a programmable delay after each rising edge of the shift clock. A black-level clamp can use the dark-reference code to pick out its samples.

The time between gate pulses sets the sensor's integration time. A programmable count of idle clocks between lines lengthens it. A timing check rejects settings that break the sensor's limits. The timing values are captured when each line sequence begins.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset, every output is low: the shift clock, the gate, the strobe, the line-start pulse, `px_active_o`, `px_class_o` and `px_index_o`.
- R2: Once `enable` is high and the settings pass the check, the shift clock stays low for `cfg_guard` clocks. The gate is then high for exactly `cfg_gate` clocks. The shift clock stays low for `cfg_guard` more clocks before its first rising edge. The gate and the shift clock are never high together.
- R3: `line_start_o` is high for exactly one clock: the first clock in which the gate is low again after a gate pulse.
- R4: A line consists of exactly N_LEAD+N_EFF+N_TRAIL shift-clock periods. Each period is `cfg_hi` clocks high followed by `cfg_lo` clocks low.
- R5: While a line runs, `px_active_o` is high and `px_class_o` gives the class of the current period. Code 0 is a leading dummy. Code 1 is a dark-reference period, which covers periods BLACK_FIRST to BLACK_FIRST+N_BLACK-1. Code 2 is an image period, which covers periods N_LEAD to N_LEAD+N_EFF-1. Code 3 is a trailing dummy. Outside a line, `px_active_o` is low and the code is 0.
- R6: `px_index_o` counts from 0 to N_EFF-1 across the image periods and is 0 at all other times.
- R7: `sample_o` is high for one clock in every period. It fires `cfg_dly` clocks after the clock in which the shift clock rises.
- R8: After the last period of a line there are `cfg_extra` idle clocks. The next guard interval then begins. Zero means no idle clocks.
- R9: If `enable` falls while a line sequence is running, that line still completes. No further gate pulse follows, and both drive outputs stay low.
- R10: The sequence does not start, and the outputs stay idle, if any of these holds: `cfg_hi`+`cfg_lo` is shorter than the minimum period (200 ns); the high share of the period is outside 40 % to 60 %; `cfg_guard` or `cfg_gate` is below 500 ns; `cfg_dly` does not exceed the 110 ns settle time; or `cfg_dly` is not less than the period.
- R11: The timing inputs are captured at the start of each line sequence. A change to them during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; line sequences repeat while it is high |
| cfg_hi | input | CW | Shift-clock high time in system clocks |
| cfg_lo | input | CW | Shift-clock low time in system clocks |
| cfg_dly | input | CW | Sample-strobe delay after the shift-clock rising edge |
| cfg_guard | input | GW | Shift-clock idle time on each side of the gate pulse |
| cfg_gate | input | GW | Gate pulse width in system clocks |
| cfg_extra | input | XW | Extra idle clocks between lines |
| sclk_o | output | 1 | Pixel shift clock to the sensor |
| gate_o | output | 1 | Readout-gate pulse to the sensor |
| sample_o | output | 1 | One-clock converter sample strobe |
| line_start_o | output | 1 | One-clock marker when the gate pulse ends |
| px_active_o | output | 1 | High while line periods are being clocked out |
| px_class_o | output | 2 | Period class: 0 dummy, 1 dark reference, 2 image, 3 trailing |
| px_index_o | output | $clog2(N_EFF) | Image-pixel index |

## Verification
The hardest case to reach from the ports is a timing change that arrives in the middle of a line. The design must keep using the values it captured when the line began, while the new values must still be legal by the next start so the run can continue. The bench writes a different high/low split partway through the first line and restores the original before that line ends. It then compares every clock of that line against the waveform computed from the original settings. A second hard case is dropping `enable` in the middle of a line. The bench drops it during the last sequence of each run and checks that the line finishes and that no further gate pulse appears.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_GATE  = 3'd2,
        ST_POST  = 3'd3,
        ST_LINE  = 3'd4,
        ST_EXTRA = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        PX_DUMMY     = 2'd0,
        PX_BLACK     = 2'd1,
        PX_EFFECTIVE = 2'd2,
        PX_TRAIL     = 2'd3
    } px_class_e;

endpackage

// File: rtl/ccd_cfg_check.sv
module ccd_cfg_check #(
    parameter int CLK_NS        = 20,
    parameter int MIN_PERIOD_NS = 200,
    parameter int MIN_HOLD_NS   = 500,
    parameter int SETTLE_NS     = 110,
    parameter int CW            = 8,
    parameter int GW            = 8
) (
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] dly,
    input  logic [GW-1:0] guard,
    input  logic [GW-1:0] gate,
    output logic          ok
);
    localparam int MIN_PER_CLKS  = (MIN_PERIOD_NS + CLK_NS - 1) / CLK_NS;
    localparam int MIN_HOLD_CLKS = (MIN_HOLD_NS + CLK_NS - 1) / CLK_NS;
    localparam int MIN_DLY_CLKS  = SETTLE_NS / CLK_NS + 1;
    localparam int WW            = CW + 5;

    logic [WW-1:0] per_w;
    logic [WW-1:0] hi_x10;
    logic          rate_ok, duty_ok, dly_ok, hold_ok;

    always_comb begin
        per_w   = WW'(hi) + WW'(lo);
        hi_x10  = WW'(hi) * WW'(10);
        rate_ok = per_w >= WW'(MIN_PER_CLKS);
        duty_ok = (hi_x10 >= per_w * WW'(4)) && (hi_x10 <= per_w * WW'(6));
        dly_ok  = (WW'(dly) >= WW'(MIN_DLY_CLKS)) && (WW'(dly) < per_w);
        hold_ok = (int'(guard) >= MIN_HOLD_CLKS) && (int'(gate) >= MIN_HOLD_CLKS);
        ok      = rate_ok && duty_ok && dly_ok && hold_ok;
    end

endmodule

// File: rtl/ccd_px_classifier.sv
module ccd_px_classifier
    import ccd_timer_pkg::*;
#(
    parameter int N_LEAD      = 33,
    parameter int BLACK_FIRST = 12,
    parameter int N_BLACK     = 18,
    parameter int N_EFF       = 2048,
    parameter int PIX_W       = 12,
    parameter int EIDX_W      = 11
) (
    input  logic [PIX_W-1:0]  pix,
    output px_class_e         cls,
    output logic [EIDX_W-1:0] idx
);
    localparam int EFF_END = N_LEAD + N_EFF;

    logic in_black;

    generate
        if (N_BLACK > 0) begin : g_black
            assign in_black = (pix >= PIX_W'(BLACK_FIRST)) &&
                              (pix <  PIX_W'(BLACK_FIRST + N_BLACK));
        end else begin : g_no_black
            assign in_black = 1'b0;
        end
    endgenerate

    always_comb begin
        cls = PX_DUMMY;
        idx = '0;
        if (pix < PIX_W'(N_LEAD)) begin
            cls = in_black ? PX_BLACK : PX_DUMMY;
        end else if (pix < PIX_W'(EFF_END)) begin
            cls = PX_EFFECTIVE;
            idx = EIDX_W'(pix - PIX_W'(N_LEAD));
        end else begin
            cls = PX_TRAIL;
        end
    end

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_timer_pkg::*;
#(
    parameter int CLK_NS        = 20,
    parameter int MIN_PERIOD_NS = 200,
    parameter int MIN_HOLD_NS   = 500,
    parameter int SETTLE_NS     = 110,
    parameter int N_LEAD        = 33,
    parameter int BLACK_FIRST   = 12,
    parameter int N_BLACK       = 18,
    parameter int N_EFF         = 2048,
    parameter int N_TRAIL       = 6,
    parameter int CW            = 8,
    parameter int GW            = 8,
    parameter int XW            = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [CW-1:0]            cfg_hi,
    input  logic [CW-1:0]            cfg_lo,
    input  logic [CW-1:0]            cfg_dly,
    input  logic [GW-1:0]            cfg_guard,
    input  logic [GW-1:0]            cfg_gate,
    input  logic [XW-1:0]            cfg_extra,
    output logic                     sclk_o,
    output logic                     gate_o,
    output logic                     sample_o,
    output logic                     line_start_o,
    output logic                     px_active_o,
    output logic [1:0]               px_class_o,
    output logic [$clog2(N_EFF)-1:0] px_index_o
);
    localparam int N_TOTAL = N_LEAD + N_EFF + N_TRAIL;
    localparam int PIX_W   = $clog2(N_TOTAL);
    localparam int EIDX_W  = $clog2(N_EFF);
    localparam int PW      = CW + 1;
    localparam int CNT_W   = (XW > GW) ? XW : GW;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    ph;
        logic [PIX_W-1:0] pix;
        logic [CW-1:0]    hi;
        logic [CW-1:0]    lo;
        logic [CW-1:0]    dly;
        logic [GW-1:0]    guard;
        logic [GW-1:0]    gate;
        logic [XW-1:0]    extra;
    } seq_t;

    typedef struct packed {
        logic              sclk;
        logic              gate;
        logic              strobe;
        logic              lstart;
        logic              active;
        px_class_e         cls;
        logic [EIDX_W-1:0] idx;
    } out_t;

    seq_t sq, sn;
    out_t oq, on;

    logic              cfg_ok;
    logic              go;
    logic [PW-1:0]     per_m1;
    px_class_e         cls_n;
    logic [EIDX_W-1:0] idx_n;

    ccd_cfg_check #(
        .CLK_NS       (CLK_NS),
        .MIN_PERIOD_NS(MIN_PERIOD_NS),
        .MIN_HOLD_NS  (MIN_HOLD_NS),
        .SETTLE_NS    (SETTLE_NS),
        .CW           (CW),
        .GW           (GW)
    ) u_cfg_check (
        .hi   (cfg_hi),
        .lo   (cfg_lo),
        .dly  (cfg_dly),
        .guard(cfg_guard),
        .gate (cfg_gate),
        .ok   (cfg_ok)
    );

    // Sequencer: next state of the line cycle
    always_comb begin
        sn     = sq;
        go     = 1'b0;
        per_m1 = {1'b0, sq.hi} + {1'b0, sq.lo} - PW'(1);
        unique case (sq.st)
            ST_IDLE: go = 1'b1;
            ST_PRE: begin
                if (sq.cnt == '0) begin
                    sn.st  = ST_GATE;
                    sn.cnt = CNT_W'(sq.gate) - CNT_W'(1);
                end else begin
                    sn.cnt = sq.cnt - CNT_W'(1);
                end
            end
            ST_GATE: begin
                if (sq.cnt == '0) begin
                    sn.st  = ST_POST;
                    sn.cnt = CNT_W'(sq.guard) - CNT_W'(1);
                end else begin
                    sn.cnt = sq.cnt - CNT_W'(1);
                end
            end
            ST_POST: begin
                if (sq.cnt == '0) begin
                    sn.st  = ST_LINE;
                    sn.ph  = '0;
                    sn.pix = '0;
                end else begin
                    sn.cnt = sq.cnt - CNT_W'(1);
                end
            end
            ST_LINE: begin
                if (sq.ph == per_m1) begin
                    sn.ph = '0;
                    if (sq.pix == PIX_W'(N_TOTAL - 1)) begin
                        if (sq.extra == '0) begin
                            go = 1'b1;
                        end else begin
                            sn.st  = ST_EXTRA;
                            sn.cnt = CNT_W'(sq.extra) - CNT_W'(1);
                        end
                    end else begin
                        sn.pix = sq.pix + PIX_W'(1);
                    end
                end else begin
                    sn.ph = sq.ph + PW'(1);
                end
            end
            ST_EXTRA: begin
                if (sq.cnt == '0) begin
                    go = 1'b1;
                end else begin
                    sn.cnt = sq.cnt - CNT_W'(1);
                end
            end
            default: sn.st = ST_IDLE;
        endcase

        // Decision point: start a new line sequence or rest
        if (go) begin
            if (enable && cfg_ok) begin
                sn.st    = ST_PRE;
                sn.cnt   = CNT_W'(cfg_guard) - CNT_W'(1);
                sn.hi    = cfg_hi;
                sn.lo    = cfg_lo;
                sn.dly   = cfg_dly;
                sn.guard = cfg_guard;
                sn.gate  = cfg_gate;
                sn.extra = cfg_extra;
            end else begin
                sn.st = ST_IDLE;
            end
        end
    end

    ccd_px_classifier #(
        .N_LEAD     (N_LEAD),
        .BLACK_FIRST(BLACK_FIRST),
        .N_BLACK    (N_BLACK),
        .N_EFF      (N_EFF),
        .PIX_W      (PIX_W),
        .EIDX_W     (EIDX_W)
    ) u_classifier (
        .pix(sn.pix),
        .cls(cls_n),
        .idx(idx_n)
    );

    // Output decode from the next state, so outputs are registered
    always_comb begin
        on        = '0;
        on.active = (sn.st == ST_LINE);
        on.sclk   = on.active && (sn.ph < {1'b0, sn.hi});
        on.strobe = on.active && (sn.ph == {1'b0, sn.dly});
        on.gate   = (sn.st == ST_GATE);
        on.lstart = (sq.st == ST_GATE) && (sn.st == ST_POST);
        on.cls    = on.active ? cls_n : PX_DUMMY;
        on.idx    = (on.active && cls_n == PX_EFFECTIVE) ? idx_n : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq <= '0;
            oq <= '0;
        end else begin
            sq <= sn;
            oq <= on;
        end
    end

    assign sclk_o       = oq.sclk;
    assign gate_o       = oq.gate;
    assign sample_o     = oq.strobe;
    assign line_start_o = oq.lstart;
    assign px_active_o  = oq.active;
    assign px_class_o   = oq.cls;
    assign px_index_o   = oq.idx;

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
    parameter int CLK_NS      = 20,
    parameter int MIN_HOLD_NS = 500,
    parameter int N_EFF       = 2048
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sclk_o,
    input logic                     gate_o,
    input logic                     sample_o,
    input logic                     line_start_o,
    input logic                     px_active_o,
    input logic [1:0]               px_class_o,
    input logic [$clog2(N_EFF)-1:0] px_index_o
);
    localparam int HOLD_CLKS = (MIN_HOLD_NS + CLK_NS - 1) / CLK_NS;

    logic [15:0] gate_hi_run;
    logic [15:0] sclk_lo_run;
    logic [15:0] gate_lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_hi_run <= '0;
            sclk_lo_run <= '0;
            gate_lo_run <= '0;
        end else begin
            gate_hi_run <= gate_o ? ((gate_hi_run == 16'hFFFF) ? gate_hi_run : gate_hi_run + 16'd1) : 16'd0;
            sclk_lo_run <= sclk_o ? 16'd0 : ((sclk_lo_run == 16'hFFFF) ? sclk_lo_run : sclk_lo_run + 16'd1);
            gate_lo_run <= gate_o ? 16'd0 : ((gate_lo_run == 16'hFFFF) ? gate_lo_run : gate_lo_run + 16'd1);
        end
    end

    AST_GATE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o) |-> int'(gate_hi_run) >= HOLD_CLKS); // R2
    AST_GUARD_BEFORE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> int'(sclk_lo_run) >= HOLD_CLKS); // R2
    AST_GUARD_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> int'(gate_lo_run) >= HOLD_CLKS); // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (!sclk_o && !px_active_o)); // R2
    AST_LSTART_AT_GATE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |-> $fell(gate_o)); // R3
    AST_GATE_FALL_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o) |-> line_start_o); // R3
    AST_STROBE_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> px_active_o); // R7
    AST_INDEX_ONLY_EFFECTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (px_class_o != 2'd2) |-> (px_index_o == '0)); // R6
    AST_IDLE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        !px_active_o |-> (px_class_o == 2'd0 && !sclk_o && !sample_o)); // R5

endmodule

bind ccd_line_timer ccd_line_timer_chk #(
    .CLK_NS     (CLK_NS),
    .MIN_HOLD_NS(MIN_HOLD_NS),
    .N_EFF      (N_EFF)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_o      (sclk_o),
    .gate_o      (gate_o),
    .sample_o    (sample_o),
    .line_start_o(line_start_o),
    .px_active_o (px_active_o),
    .px_class_o  (px_class_o),
    .px_index_o  (px_index_o)
);

// File: tb/ccd_line_timer_tb.sv
module ccd_line_timer_tb;
    localparam int LEAD  = 5;
    localparam int BFST  = 1;
    localparam int NBLK  = 3;
    localparam int NEFF  = 16;
    localparam int NTRL  = 2;
    localparam int TOT   = LEAD + NEFF + NTRL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] cfg_hi = 8'd5, cfg_lo = 8'd5, cfg_dly = 8'd6;
    logic [7:0] cfg_guard = 8'd25, cfg_gate = 8'd25;
    logic [15:0] cfg_extra = 16'd0;

    logic       sclk, gate, strobe, lstart, active;
    logic [1:0] cls;
    logic [3:0] idx;

    int checks = 0;
    int errors = 0;

    ccd_line_timer #(
        .N_LEAD(LEAD), .BLACK_FIRST(BFST), .N_BLACK(NBLK),
        .N_EFF(NEFF), .N_TRAIL(NTRL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(en),
        .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_dly(cfg_dly),
        .cfg_guard(cfg_guard), .cfg_gate(cfg_gate), .cfg_extra(cfg_extra),
        .sclk_o(sclk), .gate_o(gate), .sample_o(strobe), .line_start_o(lstart),
        .px_active_o(active), .px_class_o(cls), .px_index_o(idx)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_seq(int hi, int lo, int dly, int g, int w, int x, int ncyc, bit poke);
        int per   = hi + lo;
        int ls    = 2 * g + w;
        int L     = ls + TOT * per + x;
        int stopc = ncyc - 1;
        cfg_hi = 8'(hi); cfg_lo = 8'(lo); cfg_dly = 8'(dly);
        cfg_guard = 8'(g); cfg_gate = 8'(w); cfg_extra = 16'(x);
        en = 1'b1;
        @(posedge clk);
        for (int t = 0; t < ncyc * L + 40; t++) begin
            int c = t / L;
            int p = t % L;
            bit idle = (c > stopc) || (c == stopc && p >= ls + TOT * per);
            int e_sclk = 0, e_gate = 0, e_stb = 0, e_ls = 0, e_act = 0, e_cls = 0, e_idx = 0;
            string tg;
            @(negedge clk);
            if (!idle) begin
                if (p >= g && p < g + w) e_gate = 1;
                if (p == g + w) e_ls = 1;
                if (p >= ls && p < ls + TOT * per) begin
                    int q = p - ls;
                    int pix = q / per;
                    int ph = q % per;
                    e_act = 1;
                    e_sclk = (ph < hi) ? 1 : 0;
                    e_stb = (ph == dly) ? 1 : 0;
                    if (pix < LEAD) e_cls = (pix >= BFST && pix < BFST + NBLK) ? 1 : 0;
                    else if (pix < LEAD + NEFF) begin e_cls = 2; e_idx = pix - LEAD; end
                    else e_cls = 3;
                end
            end
            tg = idle ? "R9" : ((poke && c == 0) ? "R11" : "R4");
            chk(tg, "sclk", int'(sclk), e_sclk);
            tg = idle ? "R9" : ((c > 0 && p < g + w) ? "R8" : "R2");
            chk(tg, "gate", int'(gate), e_gate);
            chk("R3", "line_start", int'(lstart), e_ls);
            chk("R7", "strobe", int'(strobe), e_stb);
            chk("R5", "active", int'(active), e_act);
            chk("R5", "class", int'(cls), e_cls);
            chk("R6", "index", int'(idx), e_idx);
            if (t == stopc * L + ls + 20) en = 1'b0;
            if (poke && t == ls + 30) begin cfg_hi = 8'(hi - 1); cfg_lo = 8'(lo + 1); end
            if (poke && t == ls + 100) begin cfg_hi = 8'(hi); cfg_lo = 8'(lo); end
        end
    endtask

    task automatic bad_cfg(int hi, int lo, int dly, int g, int w, string what);
        int bad = 0;
        cfg_hi = 8'(hi); cfg_lo = 8'(lo); cfg_dly = 8'(dly);
        cfg_guard = 8'(g); cfg_gate = 8'(w); cfg_extra = 16'd0;
        en = 1'b1;
        repeat (80) begin
            @(negedge clk);
            if (sclk || gate || active || lstart || strobe) bad = 1;
        end
        chk("R10", what, bad, 0);
        en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", int'({sclk, gate, strobe, lstart, active, cls, idx}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "outputs after reset", int'({sclk, gate, strobe, lstart, active, cls, idx}), 0);

        // R10: each rule on its own, at and just past its boundary
        bad_cfg(4, 5, 6, 25, 25, "period below minimum");
        bad_cfg(3, 7, 6, 25, 25, "duty 30 percent");
        bad_cfg(7, 3, 6, 25, 25, "duty 70 percent");
        bad_cfg(5, 5, 5, 25, 25, "strobe inside settle window");
        bad_cfg(5, 5, 10, 25, 25, "strobe beyond period");
        bad_cfg(5, 5, 6, 24, 25, "guard below minimum");
        bad_cfg(5, 5, 6, 25, 24, "gate below minimum");

        // Full lines with idle gap, mid-line change, stop after line
        run_seq(5, 5, 6, 25, 25, 3, 3, 1'b1);
        // 60 percent duty boundary, latest strobe, no idle gap
        run_seq(6, 4, 9, 25, 30, 0, 3, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule